// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits beside the special-register file of a small in-order core. It takes the register updates that happen when the pipeline raises either a general exception or a debug exception. From the faulting program counter, a cause code, an optional faulting virtual address, the current status word and the current interrupt level, it computes four things. It works out which exception is taken and which vector the fetch unit must jump to. It decides which PC and status save registers are written. It also produces the new status word.

The pipeline presents a request as a one-cycle strobe, with its data valid in that cycle. Every register update lands on the next rising clock edge. A one-cycle `vec_valid` pulse and the vector code go out on that same edge. The block accepts a request in every cycle, so there is no back-pressure. The fetch unit must take the vector on the cycle in which `vec_valid` is high. The status word is owned by the surrounding core. It enters as `cur_ps`, and its updated value leaves as `ps_out`, for the core to load when it sees `vec_valid`.

The status-word layout is fixed by the package. Bits [3:0] hold the interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag. Vector codes are user = 0, kernel = 1, double = 2 and debug = 3. The default configuration has four levels, a debug level of 3 and a double-exception PC register.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `vec_valid` is 0 and `vec_sel`, `ps_out`, every save register, and the cause, address and debug-cause outputs all read 0.
- R2: A general exception taken while the exception-mode flag (bit 4) is clear writes the PC into the level-1 slot of `epc_flat` (bits [31:0]). It selects vector 0 (user) when bit 5 is set and vector 1 (kernel) otherwise.
- R3: A general exception taken while bit 4 is set, with the double-exception register present, writes the PC to `depc_out` and selects vector 2. The level-1 PC is left unchanged.
- R4: Every taken general exception writes its cause to `cause_out`. It sets bit 4 in `ps_out`, and all other status bits are copied from `cur_ps`.
- R5: The faulting virtual address is written to `vaddr_out` only when `gen_vaddr_vld` accompanies a taken general exception. In every other case `vaddr_out` keeps its value.
- R6: A debug request is taken only when `cur_intlevel` is strictly below the debug level. A refused debug request with no general request produces no pulse and changes no output.
- R7: A taken debug exception writes `dbg_cause` to `dbgcause_out`. The PC goes into the debug level's slot of `epc_flat`, and `cur_ps` goes into the debug level's slot of `eps_flat`. The slot for level L is bits [32L-1:32(L-1)].
- R8: On a taken debug exception, `ps_out` has bits [3:0] set to the debug level and bit 4 set, with all other bits copied from `cur_ps`. The vector is 3.
- R9: Each taken request gives exactly one cycle of `vec_valid`, on the same edge as its register updates. A cycle with no request gives no pulse on the next cycle.
- R10: When general and debug requests arrive together and the debug request is taken, only the debug exception is recorded and `cause_out` is unchanged. If the debug request is refused, the general exception is taken and `dbgcause_out` is unchanged.
- R11: When the double-exception register is not configured, a general exception taken with bit 4 set writes the level-1 PC and selects vector 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_req | input | 1 | General exception strobe |
| gen_cause | input | CAUSE_W | General exception cause code |
| gen_vaddr_vld | input | 1 | Faulting address accompanies the request |
| gen_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception strobe |
| dbg_cause | input | DCAUSE_W | Debug cause bits |
| exc_pc | input | XLEN | PC of the faulting instruction |
| cur_ps | input | XLEN | Current status word |
| cur_intlevel | input | ILW | Current interrupt level |
| vec_valid | output | 1 | One-cycle vector pulse |
| vec_sel | output | 2 | Selected vector code |
| ps_out | output | XLEN | Updated status word |
| epc_flat | output | NLEVEL*XLEN | Exception PC per level, level 1 lowest |
| eps_flat | output | NLEVEL*XLEN | Saved status per level; only the debug level's slot is written |
| depc_out | output | XLEN | Double-exception PC |
| cause_out | output | CAUSE_W | General exception cause |
| vaddr_out | output | XLEN | Faulting virtual address |
| dbgcause_out | output | DCAUSE_W | Debug cause |

## Verification
The assertions take two things for granted about the configuration and the inputs. The debug level must lie between 2 and the level count. Requests must be single-cycle strobes whose PC, cause and status inputs are valid in the strobe cycle. The properties compare registered outputs one cycle after the strobe with the inputs sampled at the strobe. The bench therefore drives every input on the falling edge and holds it for one full cycle. It returns the strobes to 0 between rows, keeps `cur_intlevel` within its field width, and keeps the default debug level of 3.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PS_IL_LSB = 0;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT = 5;

  typedef enum logic [1:0] {
    VEC_USER   = 2'd0,
    VEC_KERNEL = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int ILW = 4,
  parameter int DBG_LEVEL = 3,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic           gen_req,
  input  logic           dbg_req,
  input  logic [ILW-1:0] cur_intlevel,
  input  logic           excm,
  input  logic           um,
  output logic           gen_take,
  output logic           dbg_take,
  output logic           to_depc,
  output vec_e           vec
);
  localparam logic [ILW-1:0] DBG_LVL_V = ILW'(DBG_LEVEL);

  logic dbg_allowed;
  assign dbg_allowed = cur_intlevel < DBG_LVL_V;

  always_comb begin
    dbg_take = dbg_req && dbg_allowed;
    gen_take = gen_req && !dbg_take;
    to_depc  = gen_take && excm && HAS_DEPC;
    if (dbg_take)        vec = VEC_DEBUG;
    else if (to_depc)    vec = VEC_DOUBLE;
    else if (excm)       vec = VEC_KERNEL;
    else if (um)         vec = VEC_USER;
    else                 vec = VEC_KERNEL;
  end
endmodule

// File: rtl/exc_ps_update.sv
module exc_ps_update
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILW = 4,
  parameter int DBG_LEVEL = 3
) (
  input  logic [XLEN-1:0] cur_ps,
  input  logic            dbg_take,
  output logic [XLEN-1:0] ps_next
);
  localparam logic [XLEN-1:0] IL_MASK  = XLEN'((1 << ILW) - 1) << PS_IL_LSB;
  localparam logic [XLEN-1:0] EXCM_SET = XLEN'(1) << PS_EXCM_BIT;
  localparam logic [XLEN-1:0] DBG_IL   = XLEN'(DBG_LEVEL) << PS_IL_LSB;

  always_comb begin
    if (dbg_take) ps_next = (cur_ps & ~IL_MASK) | DBG_IL | EXCM_SET;
    else          ps_next = cur_ps | EXCM_SET;
  end
endmodule

// File: rtl/exc_pc_bank.sv
module exc_pc_bank #(
  parameter int XLEN = 32,
  parameter int NLEVEL = 4,
  parameter int DBG_LEVEL = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lvl1_we,
  input  logic                   dbg_we,
  input  logic [XLEN-1:0]        pc,
  input  logic [XLEN-1:0]        ps_in,
  output logic [NLEVEL*XLEN-1:0] epc_flat,
  output logic [NLEVEL*XLEN-1:0] eps_flat
);
  for (genvar lv = 1; lv <= NLEVEL; lv++) begin : g_lvl
    logic [XLEN-1:0] epc_q;
    logic            we;
    if (lv == 1) begin : g_l1
      assign we = lvl1_we;
    end else if (lv == DBG_LEVEL) begin : g_ld
      assign we = dbg_we;
    end else begin : g_lo
      assign we = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)  epc_q <= '0;
      else if (we) epc_q <= pc;
    end
    assign epc_flat[(lv-1)*XLEN +: XLEN] = epc_q;

    if (lv == DBG_LEVEL && lv >= 2) begin : g_eps
      logic [XLEN-1:0] eps_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      eps_q <= '0;
        else if (dbg_we) eps_q <= ps_in;
      end
      assign eps_flat[(lv-1)*XLEN +: XLEN] = eps_q;
    end else begin : g_noeps
      assign eps_flat[(lv-1)*XLEN +: XLEN] = '0;
    end
  end

  // R2: level-1 save register captures the PC of the write cycle
  a_r2_epc1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    lvl1_we |=> epc_flat[XLEN-1:0] == $past(pc));
  // R3: level-1 save register untouched when it is not written
  a_r3_epc1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl1_we |=> $stable(epc_flat[XLEN-1:0]));
  // R7: debug level saves the old status word
  a_r7_eps_capture: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> eps_flat[(DBG_LEVEL-1)*XLEN +: XLEN] == $past(ps_in));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NLEVEL = 4,
  parameter int DBG_LEVEL = 3,
  parameter int ILW = 4,
  parameter int CAUSE_W = 6,
  parameter int DCAUSE_W = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gen_req,
  input  logic [CAUSE_W-1:0]     gen_cause,
  input  logic                   gen_vaddr_vld,
  input  logic [XLEN-1:0]        gen_vaddr,
  input  logic                   dbg_req,
  input  logic [DCAUSE_W-1:0]    dbg_cause,
  input  logic [XLEN-1:0]        exc_pc,
  input  logic [XLEN-1:0]        cur_ps,
  input  logic [ILW-1:0]         cur_intlevel,
  output logic                   vec_valid,
  output logic [1:0]             vec_sel,
  output logic [XLEN-1:0]        ps_out,
  output logic [NLEVEL*XLEN-1:0] epc_flat,
  output logic [NLEVEL*XLEN-1:0] eps_flat,
  output logic [XLEN-1:0]        depc_out,
  output logic [CAUSE_W-1:0]     cause_out,
  output logic [XLEN-1:0]        vaddr_out,
  output logic [DCAUSE_W-1:0]    dbgcause_out
);
  localparam logic [ILW-1:0] DBG_LVL_V = ILW'(DBG_LEVEL);

  logic            gen_take, dbg_take, to_depc;
  vec_e            vec;
  logic [XLEN-1:0] ps_next;

  exc_arbiter #(.ILW(ILW), .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) arb_i (
    .gen_req(gen_req), .dbg_req(dbg_req), .cur_intlevel(cur_intlevel),
    .excm(cur_ps[PS_EXCM_BIT]), .um(cur_ps[PS_UM_BIT]),
    .gen_take(gen_take), .dbg_take(dbg_take), .to_depc(to_depc), .vec(vec)
  );

  exc_ps_update #(.XLEN(XLEN), .ILW(ILW), .DBG_LEVEL(DBG_LEVEL)) psu_i (
    .cur_ps(cur_ps), .dbg_take(dbg_take), .ps_next(ps_next)
  );

  exc_pc_bank #(.XLEN(XLEN), .NLEVEL(NLEVEL), .DBG_LEVEL(DBG_LEVEL)) bank_i (
    .clk(clk), .rst_n(rst_n), .lvl1_we(gen_take && !to_depc), .dbg_we(dbg_take),
    .pc(exc_pc), .ps_in(cur_ps), .epc_flat(epc_flat), .eps_flat(eps_flat)
  );

  logic taken;
  assign taken = gen_take || dbg_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid    <= 1'b0;
      vec_sel      <= 2'd0;
      ps_out       <= '0;
      cause_out    <= '0;
      vaddr_out    <= '0;
      dbgcause_out <= '0;
    end else begin
      vec_valid <= taken;
      if (taken) begin
        vec_sel <= vec;
        ps_out  <= ps_next;
      end
      if (gen_take) cause_out <= gen_cause;
      if (gen_take && gen_vaddr_vld) vaddr_out <= gen_vaddr;
      if (dbg_take) dbgcause_out <= dbg_cause;
    end
  end

  if (HAS_DEPC) begin : g_depc
    logic [XLEN-1:0] depc_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       depc_q <= '0;
      else if (to_depc) depc_q <= exc_pc;
    end
    assign depc_out = depc_q;
  end else begin : g_nodepc
    assign depc_out = '0;
  end

  // R4: a general exception always leaves the exception-mode flag set
  a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && !dbg_req) |=> ps_out[PS_EXCM_BIT] && cause_out == $past(gen_cause));
  // R6: refused debug alone gives no pulse
  a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !gen_req && cur_intlevel >= DBG_LVL_V) |=> !vec_valid);
  // R8: debug entry status word
  a_r8_dbg_ps: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && cur_intlevel < DBG_LVL_V) |=>
      ps_out[ILW-1:0] == DBG_LVL_V && ps_out[PS_EXCM_BIT] && vec_sel == VEC_DEBUG);
  // R9: no request, no pulse
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_req || dbg_req) |=> !vec_valid && $stable(ps_out));
  // R10: debug wins and general cause is not recorded
  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && gen_req && cur_intlevel < DBG_LVL_V) |=> $stable(cause_out));
endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_req = 1'b0, gen_vaddr_vld = 1'b0, dbg_req = 1'b0;
  logic [5:0]  gen_cause = '0, dbg_cause = '0;
  logic [31:0] gen_vaddr = '0, exc_pc = '0, cur_ps = '0;
  logic [3:0]  cur_intlevel = '0;

  logic         vec_valid, nd_valid;
  logic [1:0]   vec_sel, nd_sel;
  logic [31:0]  ps_out, depc_out, vaddr_out, nd_ps, nd_depc, nd_vaddr;
  logic [127:0] epc_flat, eps_flat, nd_epc, nd_eps;
  logic [5:0]   cause_out, dbgcause_out, nd_cause, nd_dcause;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
    .gen_vaddr_vld(gen_vaddr_vld), .gen_vaddr(gen_vaddr), .dbg_req(dbg_req),
    .dbg_cause(dbg_cause), .exc_pc(exc_pc), .cur_ps(cur_ps), .cur_intlevel(cur_intlevel),
    .vec_valid(vec_valid), .vec_sel(vec_sel), .ps_out(ps_out), .epc_flat(epc_flat),
    .eps_flat(eps_flat), .depc_out(depc_out), .cause_out(cause_out),
    .vaddr_out(vaddr_out), .dbgcause_out(dbgcause_out)
  );

  exc_entry_seq #(.HAS_DEPC(1'b0)) dut_nd_i (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
    .gen_vaddr_vld(gen_vaddr_vld), .gen_vaddr(gen_vaddr), .dbg_req(dbg_req),
    .dbg_cause(dbg_cause), .exc_pc(exc_pc), .cur_ps(cur_ps), .cur_intlevel(cur_intlevel),
    .vec_valid(nd_valid), .vec_sel(nd_sel), .ps_out(nd_ps), .epc_flat(nd_epc),
    .eps_flat(nd_eps), .depc_out(nd_depc), .cause_out(nd_cause),
    .vaddr_out(nd_vaddr), .dbgcause_out(nd_dcause)
  );

  typedef struct packed {
    logic        gen;
    logic        dbg;
    logic        vav;
    logic [31:0] ps;
    logic [3:0]  il;
    logic        vld;
    logic [1:0]  vec;
    logic [31:0] xps;
  } row_t;

  localparam int NROW = 11;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 1'b0, 1'b0, 32'h00, 4'd0, 1'b1, 2'd1, 32'h10},
    '{1'b1, 1'b0, 1'b0, 32'h20, 4'd0, 1'b1, 2'd0, 32'h30},
    '{1'b1, 1'b0, 1'b0, 32'h10, 4'd0, 1'b1, 2'd2, 32'h10},
    '{1'b1, 1'b0, 1'b0, 32'h31, 4'd0, 1'b1, 2'd2, 32'h31},
    '{1'b0, 1'b1, 1'b0, 32'h21, 4'd1, 1'b1, 2'd3, 32'h33},
    '{1'b0, 1'b1, 1'b0, 32'h105, 4'd2, 1'b1, 2'd3, 32'h113},
    '{1'b0, 1'b1, 1'b0, 32'h00, 4'd3, 1'b0, 2'd0, 32'h113},
    '{1'b1, 1'b1, 1'b0, 32'h20, 4'd0, 1'b1, 2'd3, 32'h33},
    '{1'b1, 1'b1, 1'b0, 32'h20, 4'd5, 1'b1, 2'd0, 32'h30},
    '{1'b1, 1'b0, 1'b1, 32'h00, 4'd0, 1'b1, 2'd1, 32'h10},
    '{1'b0, 1'b0, 1'b0, 32'h00, 4'd0, 1'b0, 2'd0, 32'h10}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    gen_req = 1'b0; dbg_req = 1'b0; gen_vaddr_vld = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] l_epc1, l_epc3, l_vaddr;
    logic [5:0]  l_cause, l_dcause;
    l_epc1 = '0; l_epc3 = '0; l_vaddr = '0; l_cause = '0; l_dcause = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(vec_valid), 32'h0);
    chk("R1 ps", ps_out, 32'h0);
    chk("R1 epc", epc_flat[31:0] | epc_flat[95:64] | depc_out | vaddr_out, 32'h0);
    chk("R1 cause", 32'({cause_out, dbgcause_out}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      logic [31:0] pc;
      pc = 32'h4000_0000 + 32'(i) * 32'h100;
      gen_req = TBL[i].gen; dbg_req = TBL[i].dbg; gen_vaddr_vld = TBL[i].vav;
      cur_ps = TBL[i].ps; cur_intlevel = TBL[i].il; exc_pc = pc;
      gen_cause = 6'(i + 1); dbg_cause = 6'(i + 20); gen_vaddr = ~pc;
      @(negedge clk);
      idle();
      chk("R9 pulse", 32'(vec_valid), 32'(TBL[i].vld));
      chk("R4/R8 status", ps_out, TBL[i].xps);
      if (TBL[i].vld) chk("R2/R3/R8 vector", 32'(vec_sel), 32'(TBL[i].vec));
      if (TBL[i].vld && TBL[i].vec == 2'd3) begin
        chk("R7 epc dbg", epc_flat[95:64], pc);
        chk("R7 eps dbg", eps_flat[95:64], TBL[i].ps);
        chk("R7 dcause", 32'(dbgcause_out), 32'(6'(i + 20)));
        chk("R10 cause kept", 32'(cause_out), 32'(l_cause));
        l_epc3 = pc; l_dcause = 6'(i + 20);
      end else if (TBL[i].vld) begin
        chk("R4 cause", 32'(cause_out), 32'(6'(i + 1)));
        chk("R10 dcause kept", 32'(dbgcause_out), 32'(l_dcause));
        if (TBL[i].vec == 2'd2) begin
          chk("R3 depc", depc_out, pc);
          chk("R3 epc1 kept", epc_flat[31:0], l_epc1);
          chk("R11 nd vector", 32'(nd_sel), 32'd1);
          chk("R11 nd epc1", nd_epc[31:0], pc);
        end else begin
          chk("R2 epc1", epc_flat[31:0], pc);
          l_epc1 = pc;
        end
        if (TBL[i].vav) l_vaddr = ~pc;
        chk("R5 vaddr", vaddr_out, l_vaddr);
        l_cause = 6'(i + 1);
      end else begin
        chk("R6 epc dbg kept", epc_flat[95:64], l_epc3);
        chk("R6 dcause kept", 32'(dbgcause_out), 32'(l_dcause));
      end
    end

    // R9: pulse lasts one cycle after the last taken row
    @(negedge clk);
    chk("R9 no pulse", 32'(vec_valid), 32'h0);
    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerst ps", ps_out, 32'h0);
    chk("R1 rerst regs", epc_flat[31:0] | eps_flat[95:64] | depc_out | vaddr_out, 32'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule